// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a pixel clock. It drives horizontal sync, vertical sync, data enable, an active-area flag, the current pixel and line position, and an interrupt line. Software sets up the block through a small register port. Each axis has four phase lengths, and each length is written as the number of cycles (or lines) minus one. Each output has its own polarity bit. A command bit starts and stops scanning, and a vertical-sync event can raise a maskable interrupt.

A line is made of the active pixels, then the front porch, then the sync pulse, then the back porch. A frame is made of lines in the same order. Timing writes go into live registers. A shadow copy feeds the counters, and that copy is refreshed only while the block is stopped or at the end of a frame. A frame in progress is therefore never reshaped.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset the command, mask and status bits are 0, the polarity register reads 4'b1100 and every timing register reads 0. While stopped, xPos, yPos and irq are 0 and every output sits at its inactive level: hSync high, vSync high, dataEn low, activeArea low.
- R2: The register map uses regWe, regAddr and regWdata, and regRdata returns the addressed register with no added cycle. The addresses are: 0 command (bit 0), 1 interrupt mask (bit 0), 2 vsync status (bit 0), 3 polarity (bits 3:0), 4 to 7 horizontal active, front porch, sync and back porch, and 8 to 11 the same four for the vertical axis. Timing registers hold 12 bits. Unused addresses read 0.
- R3: While scanning, xPos counts 0 to H-1, where H is the sum of the four horizontal lengths with each length being its field plus one. hSync is active exactly for xPos in [Ha+Hf, Ha+Hf+Hs), where Ha, Hf and Hs are the active, front and sync lengths.
- R4: yPos advances by one when xPos wraps and wraps after V lines, where V is the vertical sum. vSync is active for whole lines with yPos in [Va+Vf, Va+Vf+Vs).
- R5: dataEn and activeArea are active only when xPos < Ha and yPos < Va while scanning.
- R6: Polarity bit 0 controls hSync, bit 1 vSync, bit 2 dataEn and bit 3 activeArea. A value of 1 makes that output active-high, and a new polarity applies from the cycle after the write.
- R7: Writing 1 to bit 0 of the command register starts scanning at (0,0) on the next cycle. Writing 0 there stops scanning: from the next cycle both positions are 0 and all outputs are inactive. Writing 1 while already scanning has no effect.
- R8: The status bit is set on the clock edge that ends the first pixel of the first vsync line. Writing 1 to status bit 0 clears it, and a set on the same edge wins over the clear.
- R9: irq is high exactly when both the status bit and the mask bit are 1.
- R10: Timing writes made while scanning take effect on the first cycle of the next frame. Timing writes made while stopped take effect when scanning starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWdata | input | 12 | Register write data |
| regRdata | output | 12 | Read data of the addressed register |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dataEn | output | 1 | Data enable |
| activeArea | output | 1 | Active-area flag |
| xPos | output | 12 | Current pixel within the line |
| yPos | output | 12 | Current line within the frame |
| irq | output | 1 | Vsync interrupt |

## Verification
The timing is tried with three shapes. The first is a small uneven frame whose phases all differ in length, which shows whether any phase boundary is off by one. The second is the minimal frame where every phase lasts one cycle, which checks the edge case where boundaries touch. The third is a larger frame, which separates correct wrap handling from accidental matches. A mid-frame timing write tells deferred loading apart from immediate loading. Polarity flips, a stop in mid-frame, and an interrupt clear timed to meet a status set check that the control paths act independently of the counters.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

  // Register addresses
  localparam int ADDR_CMD  = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_POL  = 3;
  localparam int ADDR_TIM0 = 4;

  // Timing fields: four per axis, horizontal first
  localparam int PHASES_PER_AXIS = 4;
  localparam int NUM_AXES        = 2;
  localparam int NUM_PHASE_REGS  = PHASES_PER_AXIS * NUM_AXES;
  localparam int PH_ACT   = 0;
  localparam int PH_FRONT = 1;
  localparam int PH_SYNC  = 2;
  localparam int PH_BACK  = 3;

  // Polarity bit positions
  localparam int POL_HS  = 0;
  localparam int POL_VS  = 1;
  localparam int POL_DE  = 2;
  localparam int POL_ACT = 3;
  localparam logic [3:0] POL_RESET = 4'b1100;

  // Control to datapath strobes
  typedef struct packed {
    logic run;    // scanning enabled
    logic clear;  // stop request this cycle
  } scanStrobe_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_timing_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [CNT_W-1:0]                 regWdata,
  output logic [CNT_W-1:0]                 regRdata,
  input  logic                             vsyncStart,
  output scanStrobe_t                      strb,
  output logic [NUM_PHASE_REGS*CNT_W-1:0]  timingLive,
  output logic [3:0]                       polarity,
  output logic                             irq
);

  logic cmdEn;
  logic maskVs;
  logic statVs;
  logic [3:0] polReg;

  logic wrCmd, wrMask, wrStat, wrPol;
  assign wrCmd  = regWe && (regAddr == ADDR_W'(ADDR_CMD));
  assign wrMask = regWe && (regAddr == ADDR_W'(ADDR_MASK));
  assign wrStat = regWe && (regAddr == ADDR_W'(ADDR_STAT));
  assign wrPol  = regWe && (regAddr == ADDR_W'(ADDR_POL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdEn  <= 1'b0;
      maskVs <= 1'b0;
      polReg <= POL_RESET;
    end else begin
      if (wrCmd)  cmdEn  <= regWdata[0];
      if (wrMask) maskVs <= regWdata[0];
      if (wrPol)  polReg <= regWdata[3:0];
    end
  end

  // Status: set by vsync start, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      statVs <= 1'b0;
    else if (vsyncStart)            statVs <= 1'b1;
    else if (wrStat && regWdata[0]) statVs <= 1'b0;
  end

  // Live timing registers
  for (genvar g = 0; g < NUM_PHASE_REGS; g++) begin : gTim
    logic [CNT_W-1:0] val;
    logic hit;
    assign hit = regWe && (regAddr == ADDR_W'(ADDR_TIM0 + g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    val <= '0;
      else if (hit) val <= regWdata;
    end
    assign timingLive[g*CNT_W +: CNT_W] = val;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CMD))  regRdata = CNT_W'(cmdEn);
    if (regAddr == ADDR_W'(ADDR_MASK)) regRdata = CNT_W'(maskVs);
    if (regAddr == ADDR_W'(ADDR_STAT)) regRdata = CNT_W'(statVs);
    if (regAddr == ADDR_W'(ADDR_POL))  regRdata = CNT_W'(polReg);
    for (int i = 0; i < NUM_PHASE_REGS; i++) begin
      if (regAddr == ADDR_W'(ADDR_TIM0 + i)) regRdata = timingLive[i*CNT_W +: CNT_W];
    end
  end

  assign strb.run   = cmdEn;
  assign strb.clear = wrCmd && !regWdata[0];
  assign polarity   = polReg;
  assign irq        = statVs & maskVs;

  // R8
  stat_set_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVs) |-> $past(vsyncStart));

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && regWdata[0] && !vsyncStart) |=> !statVs);

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_timing_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  scanStrobe_t                      strb,
  input  logic [NUM_PHASE_REGS*CNT_W-1:0]  timingLive,
  input  logic [3:0]                       polarity,
  output logic                             vsyncStart,
  output logic                             hSyncO,
  output logic                             vSyncO,
  output logic                             dataEnO,
  output logic                             activeO,
  output logic [CNT_W-1:0]                 xPos,
  output logic [CNT_W-1:0]                 yPos
);

  localparam int SUM_W = CNT_W + 2;

  logic [NUM_PHASE_REGS*CNT_W-1:0] shadow;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic [NUM_AXES-1:0][CNT_W-1:0] pos;
  logic [NUM_AXES-1:0][SUM_W-1:0] bFront, bSync, bBack, bLast;
  logic [NUM_AXES-1:0] inAct, inSync, atLast;
  logic frameEnd;

  assign pos[0] = hCnt;
  assign pos[1] = vCnt;

  // Phase boundaries per axis from the shadow copy
  for (genvar a = 0; a < NUM_AXES; a++) begin : gAxis
    localparam int BASE = a * PHASES_PER_AXIS;
    logic [SUM_W-1:0] lenAct, lenFront, lenSync, lenBack, p;
    assign lenAct   = SUM_W'(shadow[(BASE+PH_ACT)*CNT_W   +: CNT_W]) + SUM_W'(1);
    assign lenFront = SUM_W'(shadow[(BASE+PH_FRONT)*CNT_W +: CNT_W]) + SUM_W'(1);
    assign lenSync  = SUM_W'(shadow[(BASE+PH_SYNC)*CNT_W  +: CNT_W]) + SUM_W'(1);
    assign lenBack  = SUM_W'(shadow[(BASE+PH_BACK)*CNT_W  +: CNT_W]);
    assign bFront[a] = lenAct;
    assign bSync[a]  = bFront[a] + lenFront;
    assign bBack[a]  = bSync[a] + lenSync;
    assign bLast[a]  = bBack[a] + lenBack;
    assign p         = SUM_W'(pos[a]);
    assign inAct[a]  = p < bFront[a];
    assign inSync[a] = (p >= bSync[a]) && (p < bBack[a]);
    assign atLast[a] = p == bLast[a];
  end

  assign frameEnd = strb.run && atLast[0] && atLast[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        shadow <= '0;
    else if (!strb.run || frameEnd)   shadow <= timingLive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.clear || !strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (atLast[0]) begin
      hCnt <= '0;
      vCnt <= atLast[1] ? '0 : vCnt + CNT_W'(1);
    end else begin
      hCnt <= hCnt + CNT_W'(1);
    end
  end

  assign vsyncStart = strb.run && (hCnt == '0) && (SUM_W'(vCnt) == bSync[1]);

  logic dispOn;
  assign dispOn  = strb.run && inAct[0] && inAct[1];
  assign hSyncO  = (strb.run && inSync[0]) ? polarity[POL_HS] : ~polarity[POL_HS];
  assign vSyncO  = (strb.run && inSync[1]) ? polarity[POL_VS] : ~polarity[POL_VS];
  assign dataEnO = dispOn ? polarity[POL_DE]  : ~polarity[POL_DE];
  assign activeO = dispOn ? polarity[POL_ACT] : ~polarity[POL_ACT];
  assign xPos    = hCnt;
  assign yPos    = vCnt;

  // R3
  h_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (SUM_W'(hCnt) <= bLast[0]));

  // R3
  h_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear && !atLast[0]) |=> (hCnt == $past(hCnt) + CNT_W'(1)));

  // R7
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (hCnt == '0 && vCnt == '0));

  // R5
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataEnO == polarity[POL_DE]) |-> (hSyncO != polarity[POL_HS]));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !frameEnd) |=> $stable(shadow));

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              pixClk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              hSync,
  output logic              vSync,
  output logic              dataEn,
  output logic              activeArea,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos,
  output logic              irq
);

  scanStrobe_t strb;
  logic [NUM_PHASE_REGS*CNT_W-1:0] timingLive;
  logic [3:0] polarity;
  logic vsyncStart;

  scan_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (pixClk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .vsyncStart (vsyncStart),
    .strb       (strb),
    .timingLive (timingLive),
    .polarity   (polarity),
    .irq        (irq)
  );

  scan_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (pixClk),
    .rstN       (rstN),
    .strb       (strb),
    .timingLive (timingLive),
    .polarity   (polarity),
    .vsyncStart (vsyncStart),
    .hSyncO     (hSync),
    .vSyncO     (vSync),
    .dataEnO    (dataEn),
    .activeO    (activeArea),
    .xPos       (xPos),
    .yPos       (yPos)
  );

endmodule

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
module scan_timing_gen_tb;

  logic pixClk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = 4'd2;
  logic [11:0] regWdata = '0;
  logic [11:0] regRdata, xPos, yPos;
  logic hSync, vSync, dataEn, activeArea, irq;

  int vectors = 0;
  int fails = 0;
  bit cmpOn = 0;

  always #4 pixClk = ~pixClk;  // 125 MHz

  scan_timing_gen u_dut (
    .pixClk(pixClk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hSync(hSync), .vSync(vSync),
    .dataEn(dataEn), .activeArea(activeArea), .xPos(xPos), .yPos(yPos), .irq(irq)
  );

  // Behavioural reference model
  int live[8];
  int sh[8];
  int mH = 0, mV = 0;
  bit mRun = 0, mMask = 0, mStat = 0;
  bit [3:0] mPol = 4'b1100;
  int hL, vL;
  bit vsS, fEnd, clr;

  always @(posedge pixClk) begin
    cmpOn = 1;
    if (!rstN) begin
      mH = 0; mV = 0; mRun = 0; mMask = 0; mStat = 0; mPol = 4'b1100;
      for (int i = 0; i < 8; i++) begin live[i] = 0; sh[i] = 0; end
    end else begin
      hL = sh[0] + sh[1] + sh[2] + sh[3] + 3;
      vL = sh[4] + sh[5] + sh[6] + sh[7] + 3;
      vsS = mRun && mH == 0 && mV == sh[4] + sh[5] + 2;
      fEnd = mRun && mH == hL && mV == vL;
      clr = regWe && regAddr == 0 && regWdata[0] == 0;
      if (clr || !mRun) begin mH = 0; mV = 0; end
      else if (mH == hL) begin mH = 0; mV = (mV == vL) ? 0 : mV + 1; end
      else mH = mH + 1;
      if (!mRun || fEnd) for (int i = 0; i < 8; i++) sh[i] = live[i];
      if (vsS) mStat = 1;
      else if (regWe && regAddr == 2 && regWdata[0]) mStat = 0;
      if (regWe) begin
        if (regAddr == 0) mRun = regWdata[0];
        if (regAddr == 1) mMask = regWdata[0];
        if (regAddr == 3) mPol = regWdata[3:0];
        if (regAddr >= 4 && regAddr <= 11) live[regAddr-4] = int'(regWdata);
      end
    end
  end

  function automatic int expRd(input int a);
    if (a == 0) return int'(mRun);
    if (a == 1) return int'(mMask);
    if (a == 2) return int'(mStat);
    if (a == 3) return int'(mPol);
    if (a >= 4 && a <= 11) return live[a-4];
    return 0;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison
  always @(negedge pixClk) if (cmpOn) begin
    bit hA, vA, hS, vS, on;
    hA = mH <= sh[0];
    vA = mV <= sh[4];
    hS = mH >= sh[0] + sh[1] + 2 && mH <= sh[0] + sh[1] + sh[2] + 2;
    vS = mV >= sh[4] + sh[5] + 2 && mV <= sh[4] + sh[5] + sh[6] + 2;
    on = mRun && hA && vA;
    cmp("R3 R6", "hSync", 32'(hSync), 32'((mRun && hS) ? mPol[0] : !mPol[0]));
    cmp("R4 R6", "vSync", 32'(vSync), 32'((mRun && vS) ? mPol[1] : !mPol[1]));
    cmp("R5 R6", "dataEn", 32'(dataEn), 32'(on ? mPol[2] : !mPol[2]));
    cmp("R5 R6", "activeArea", 32'(activeArea), 32'(on ? mPol[3] : !mPol[3]));
    cmp("R3 R7 R10", "xPos", 32'(xPos), 32'(mH));
    cmp("R4 R7 R10", "yPos", 32'(yPos), 32'(mV));
    cmp("R9", "irq", 32'(irq), 32'(mStat && mMask));
    cmp("R2 R8", "regRdata", 32'(regRdata), 32'(expRd(int'(regAddr))));
  end

  task automatic wr(input int a, input int d);
    @(posedge pixClk); #1;
    regWe = 1; regAddr = 4'(a); regWdata = 12'(d);
    @(posedge pixClk); #1;
    regWe = 0; regAddr = 4'd2;
  endtask

  task automatic rdChk(input string tag, input int a, input int exp);
    @(posedge pixClk); #1;
    regAddr = 4'(a);
    #2;
    cmp(tag, "readback", 32'(regRdata), 32'(exp));
    regAddr = 4'd2;
  endtask

  task automatic cfg(input int ha, input int hf, input int hs, input int hb,
                     input int va, input int vf, input int vs, input int vb);
    wr(4, ha); wr(5, hf); wr(6, hs); wr(7, hb);
    wr(8, va); wr(9, vf); wr(10, vs); wr(11, vb);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge pixClk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge pixClk);
    fails++;
    $display("FAIL R7 watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    #1 rstN = 1;
    @(negedge pixClk);
    // R1 reset state
    cmp("R1", "hSync idle", 32'(hSync), 32'(1));
    cmp("R1", "dataEn idle", 32'(dataEn), 32'(0));
    cmp("R1", "irq idle", 32'(irq), 32'(0));
    rdChk("R1", 3, 12);
    rdChk("R1", 4, 0);

    // R2 program and read back an uneven frame
    cfg(3, 1, 1, 0, 2, 0, 1, 0);
    rdChk("R2", 4, 3); rdChk("R2", 5, 1); rdChk("R2", 6, 1); rdChk("R2", 7, 0);
    rdChk("R2", 8, 2); rdChk("R2", 10, 1); rdChk("R2", 12, 0);
    wr(1, 1);
    rdChk("R2", 1, 1);

    // R7 start
    wr(0, 1);
    @(negedge pixClk);
    cmp("R7", "start x", 32'(xPos), 32'(0));
    cmp("R7", "start de", 32'(dataEn), 32'(1));
    idle(140);
    rdChk("R8", 2, 1);
    cmp("R9", "irq masked on", 32'(irq), 32'(1));
    wr(1, 0);
    @(negedge pixClk);
    cmp("R9", "irq masked off", 32'(irq), 32'(0));
    wr(2, 1);
    wr(1, 1);

    // R10 mid-frame timing change
    while (!(mV == 1 && mH == 0)) @(posedge pixClk);
    wr(4, 7);
    do @(negedge pixClk); while (xPos != 8);
    @(negedge pixClk);
    cmp("R10", "old line length kept", 32'(xPos), 32'(0));
    idle(200);

    // R6 polarity flip to all active-high
    wr(3, 15);
    do @(negedge pixClk); while (!(xPos == 0 && yPos == 0));
    cmp("R6", "hSync inactive low", 32'(hSync), 32'(0));
    cmp("R6", "vSync inactive low", 32'(vSync), 32'(0));
    idle(100);

    // R8 set wins over clear
    do begin @(posedge pixClk); #1; end
    while (!(mRun && mH == 0 && mV == sh[4] + sh[5] + 2));
    regWe = 1; regAddr = 4'd2; regWdata = 12'd1;
    @(posedge pixClk); #1;
    regWe = 0;
    #2;
    cmp("R8", "set wins", 32'(regRdata), 32'(1));

    // R7 stop mid-frame
    idle(17);
    wr(0, 0);
    @(negedge pixClk);
    cmp("R7", "stop x", 32'(xPos), 32'(0));
    cmp("R7", "stop y", 32'(yPos), 32'(0));
    cmp("R7", "stop de", 32'(dataEn), 32'(0));
    wr(3, 12);

    // Minimal frame, every phase one cycle
    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    wr(0, 1);
    idle(60);
    wr(0, 0);

    // Larger frame
    cfg(15, 3, 4, 2, 5, 1, 2, 1);
    wr(0, 1);
    wr(0, 1);
    idle(800);

    summary();
    $finish;
  end

endmodule